// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a processor three 8-bit general-purpose parallel ports, called A, B and C. Port C is split into an upper and a lower nibble whose directions are chosen separately, so it can serve as one 8-bit port or as two 4-bit ports. The processor reaches the block through a small asynchronous-style bus: an active-low chip select, active-low read and write strobes, a 2-bit register address and an 8-bit data bus. All four bus inputs are sampled on the block clock.

A write to the control address does one of two things, chosen by data bit 7. With bit 7 high it redefines the direction of every port group and clears all output latches. With bit 7 low it sets or clears one port C bit and leaves everything else alone. Output-configured ports drive their latched value with the matching output-enable bits high. Input-configured ports have their enables low and return the live pin value when read. Strobed handshake and bidirectional transfers belong to a separate block. The group-mode fields of a mode word are not used here.

The bus has no valid/ready handshake and no back-pressure. Every write is accepted in the clock edge that first sees the strobe active. Every read is answered combinationally while the strobe is held.

Top module: `ppio_ctrl`

## Requirements
- R1: After reset every output-enable bit is 0, every output latch holds 0x00, and reading a port returns its pins.
- R2: The address selects the target: 0 is port A, 1 is port B, 2 is port C and 3 is the control register.
- R3: A control write with bit 7 = 1 sets the directions, with 1 meaning input: bit 4 controls port A, bit 3 controls port C bits 7:4, bit 1 controls port B, and bit 0 controls port C bits 3:0. The enables of an output group are all 1 and those of an input group are all 0.
- R4: A control write with bit 7 = 1 clears the latches of ports A, B and C to 0x00.
- R5: A control write with bit 7 = 0 writes bit 0 into port C bit number bits 3:1. Bits 6:4 have no effect, and no other latch bit and no direction changes.
- R6: A write to a port address stores the data byte in that port's latch, and the latch holds it until the next write that targets it.
- R7: A port read returns the latch for output-configured bits and the live pin value for input-configured bits, with each port C nibble following its own direction.
- R8: A read of the control address returns 0xFF.
- R9: The read data bus is 0x00 unless chip select and read strobe are both low.
- R10: A write strobe held low for several cycles performs exactly one write, using the data present in its first active cycle. Write strobes with chip select high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data from processor |
| rdata | output | 8 | Read data to processor |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin input |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
The mixed read path is the hardest case to reach from the ports. It occurs when some port C bits come from the latch and others from the pins, and the latch and pin values differ in every bit. The bench steps through all sixteen direction combinations. In each one it loads latch values that are complementary to the pin values, so every read bit shows which source it came from. For the single-bit command, the bench walks every bit index with both values and puts junk in the ignored field. It then compares the whole port C latch against a running model, so a change to any neighbouring bit is caught.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
  typedef enum logic [1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CTL = 2'd3
  } ppio_sel_e;

  // control word field positions
  localparam int CW_KIND    = 7;
  localparam int CW_DIR_A   = 4;
  localparam int CW_DIR_CU  = 3;
  localparam int CW_DIR_B   = 1;
  localparam int CW_DIR_CL  = 0;
  localparam int CW_BIT_VAL = 0;
  localparam int CW_IDX_LO  = 1;
endpackage

// File: rtl/ppio_strobe.sv
module ppio_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic wr_pulse,
  output logic rd_act
);
  logic wr_act, wr_seen;

  assign wr_act   = !cs_n && !wr_n;
  assign wr_pulse = wr_act && !wr_seen;
  assign rd_act   = !cs_n && !rd_n;

  always_ff @(posedge clk) begin
    if (!rst_n) wr_seen <= 1'b0;
    else        wr_seen <= wr_act;
  end

  p_one_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);
endmodule

// File: rtl/ppio_cfg.sv
module ppio_cfg
  import ppio_pkg::*;
#(
  parameter int PORT_W = 8,
  localparam int IDX_W = $clog2(PORT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pulse,
  input  logic [1:0]        addr,
  input  logic [7:0]        wdata,
  output logic              in_a,
  output logic              in_b,
  output logic              in_cu,
  output logic              in_cl,
  output logic [PORT_W-1:0] lat_a,
  output logic [PORT_W-1:0] lat_b,
  output logic [PORT_W-1:0] lat_c
);
  logic             is_mode;
  logic [IDX_W-1:0] bit_idx;
  logic             unused_cw;

  assign is_mode   = wdata[CW_KIND];
  assign bit_idx   = wdata[CW_IDX_LO +: IDX_W];
  assign unused_cw = ^wdata[6:5] ^ wdata[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_a  <= 1'b1;
      in_b  <= 1'b1;
      in_cu <= 1'b1;
      in_cl <= 1'b1;
      lat_a <= '0;
      lat_b <= '0;
      lat_c <= '0;
    end else if (wr_pulse) begin
      case (ppio_sel_e'(addr))
        SEL_A: lat_a <= wdata[PORT_W-1:0];
        SEL_B: lat_b <= wdata[PORT_W-1:0];
        SEL_C: lat_c <= wdata[PORT_W-1:0];
        default: begin
          if (is_mode) begin
            in_a  <= wdata[CW_DIR_A];
            in_b  <= wdata[CW_DIR_B];
            in_cu <= wdata[CW_DIR_CU];
            in_cl <= wdata[CW_DIR_CL];
            lat_a <= '0;
            lat_b <= '0;
            lat_c <= '0;
          end else begin
            lat_c[bit_idx] <= wdata[CW_BIT_VAL];
          end
        end
      endcase
    end
  end

  p_mode_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && addr == 2'd3 && wdata[7]) |=>
      (lat_a == '0 && lat_b == '0 && lat_c == '0));

  p_bsr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && addr == 2'd3 && !wdata[7]) |=>
      ($countones(lat_c ^ $past(lat_c)) <= 1 && $stable(lat_a) && $stable(lat_b)
       && $stable({in_a, in_b, in_cu, in_cl})));

  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pulse |=> ($stable(lat_a) && $stable(lat_b) && $stable(lat_c)
                   && $stable({in_a, in_b, in_cu, in_cl})));
endmodule

// File: rtl/ppio_rdmux.sv
module ppio_rdmux
  import ppio_pkg::*;
#(
  parameter int PORT_W = 8,
  localparam int HALF = PORT_W / 2
) (
  input  logic              rd_act,
  input  logic [1:0]        addr,
  input  logic              in_a,
  input  logic              in_b,
  input  logic              in_cu,
  input  logic              in_cl,
  input  logic [PORT_W-1:0] lat_a,
  input  logic [PORT_W-1:0] lat_b,
  input  logic [PORT_W-1:0] lat_c,
  input  logic [PORT_W-1:0] pin_a,
  input  logic [PORT_W-1:0] pin_b,
  input  logic [PORT_W-1:0] pin_c,
  output logic [PORT_W-1:0] rdata
);
  logic [PORT_W-1:0] view_a, view_b, view_c;
  logic [1:0]        c_in_half;

  assign view_a    = in_a ? pin_a : lat_a;
  assign view_b    = in_b ? pin_b : lat_b;
  assign c_in_half = {in_cu, in_cl};

  for (genvar h = 0; h < 2; h++) begin : g_c_half
    assign view_c[h*HALF +: HALF] = c_in_half[h] ? pin_c[h*HALF +: HALF]
                                                 : lat_c[h*HALF +: HALF];
  end

  always_comb begin
    rdata = '0;
    if (rd_act) begin
      case (ppio_sel_e'(addr))
        SEL_A:   rdata = view_a;
        SEL_B:   rdata = view_b;
        SEL_C:   rdata = view_c;
        default: rdata = '1;
      endcase
    end
  end
endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [PORT_W-1:0] pa_in,
  output logic [PORT_W-1:0] pa_out,
  output logic [PORT_W-1:0] pa_oe,
  input  logic [PORT_W-1:0] pb_in,
  output logic [PORT_W-1:0] pb_out,
  output logic [PORT_W-1:0] pb_oe,
  input  logic [PORT_W-1:0] pc_in,
  output logic [PORT_W-1:0] pc_out,
  output logic [PORT_W-1:0] pc_oe
);
  localparam int HALF = PORT_W / 2;

  logic wr_pulse, rd_act;
  logic in_a, in_b, in_cu, in_cl;

  ppio_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .wr_pulse(wr_pulse), .rd_act(rd_act)
  );

  ppio_cfg #(.PORT_W(PORT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .addr(addr), .wdata(wdata),
    .in_a(in_a), .in_b(in_b), .in_cu(in_cu), .in_cl(in_cl),
    .lat_a(pa_out), .lat_b(pb_out), .lat_c(pc_out)
  );

  ppio_rdmux #(.PORT_W(PORT_W)) u_rdmux (
    .rd_act(rd_act), .addr(addr),
    .in_a(in_a), .in_b(in_b), .in_cu(in_cu), .in_cl(in_cl),
    .lat_a(pa_out), .lat_b(pb_out), .lat_c(pc_out),
    .pin_a(pa_in), .pin_b(pb_in), .pin_c(pc_in),
    .rdata(rdata)
  );

  assign pa_oe = {PORT_W{~in_a}};
  assign pb_oe = {PORT_W{~in_b}};
  assign pc_oe = {{HALF{~in_cu}}, {HALF{~in_cl}}};

  p_idle_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> (rdata == '0));

  p_ctl_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_n && addr == 2'd3) |-> (rdata == 8'hFF));

  p_oe_follows_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_n && $past(cs_n || wr_n) && addr == 2'd3 && wdata[7])
      |=> (pa_oe == {PORT_W{~$past(wdata[4])}} && pb_oe == {PORT_W{~$past(wdata[1])}}));

  p_reset_idle_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0));
endmodule

// File: tb/ppio_ctrl_tb.sv
module ppio_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ppio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    #1 d = rdata;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv, mdl, exp_rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 pc_oe", pc_oe, 8'h00);
    chk("R1 latches", pa_out | pb_out | pc_out, 8'h00);
    pa_in = 8'h5A;
    bus_rd(2'd0, rv);
    chk("R1 read pins", rv, 8'h5A);

    // R9: idle bus and unselected read
    #1 chk("R9 idle", rdata, 8'h00);
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; addr = 2'd3;
    #1 chk("R9 cs high", rdata, 8'h00);
    rd_n = 1'b1;

    // R8: control read
    bus_rd(2'd3, rv);
    chk("R8 ctl read", rv, 8'hFF);

    // R2 R3 R6 R7: sweep all direction combinations
    for (int d = 0; d < 16; d++) begin
      logic [7:0] mw, va, vb, vc;
      mw = 8'h80 | {3'b0, d[3], d[2], 1'b0, d[1], d[0]} | ((d & 3) << 5) | ((d & 1) << 2);
      bus_wr(2'd3, mw);
      chk("R3 pa_oe", pa_oe, d[3] ? 8'h00 : 8'hFF);
      chk("R3 pb_oe", pb_oe, d[1] ? 8'h00 : 8'hFF);
      chk("R3 pc_oe", pc_oe, {d[2] ? 4'h0 : 4'hF, d[0] ? 4'h0 : 4'hF});
      va = 8'(d * 17 + 3); vb = 8'(8'hA5 ^ d); vc = 8'(8'hC3 ^ (d << 2));
      pa_in = ~va; pb_in = ~vb; pc_in = ~vc;
      bus_wr(2'd0, va);
      bus_wr(2'd1, vb);
      bus_wr(2'd2, vc);
      chk("R6 pa_out", pa_out, va);
      chk("R6 pb_out", pb_out, vb);
      chk("R6 pc_out", pc_out, vc);
      bus_rd(2'd0, rv);
      chk("R7 R2 read A", rv, d[3] ? ~va : va);
      bus_rd(2'd1, rv);
      chk("R7 R2 read B", rv, d[1] ? ~vb : vb);
      exp_rd = {d[2] ? ~vc[7:4] : vc[7:4], d[0] ? ~vc[3:0] : vc[3:0]};
      bus_rd(2'd2, rv);
      chk("R7 R2 read C halves", rv, exp_rd);
    end

    // R4: mode word clears latches (all outputs stay selected)
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd0, 8'h11); bus_wr(2'd1, 8'h22); bus_wr(2'd2, 8'h33);
    bus_wr(2'd3, 8'h80);
    chk("R4 pa_out", pa_out, 8'h00);
    chk("R4 pb_out", pb_out, 8'h00);
    chk("R4 pc_out", pc_out, 8'h00);

    // R5: bit set/reset walk with junk in bits 6:4
    mdl = 8'h00;
    for (int v = 1; v >= 0; v--) begin
      for (int i = 0; i < 8; i++) begin
        bus_wr(2'd3, 8'((((i * 3 + v) & 7) << 4) | (i << 1) | v));
        mdl[i] = v[0];
        chk("R5 pc_out", pc_out, mdl);
        chk("R5 dirs", pa_oe & pb_oe & pc_oe, 8'hFF);
        chk("R5 others", pa_out | pb_out, 8'h00);
      end
    end

    // R10: held strobe writes once with first data
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = 2'd0; wdata = 8'h6C;
    @(negedge clk); wdata = 8'h93;
    @(negedge clk); addr = 2'd1;
    @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
    chk("R10 held A", pa_out, 8'h6C);
    chk("R10 held B", pb_out, 8'h00);
    @(negedge clk); cs_n = 1'b1; wr_n = 1'b0; addr = 2'd0; wdata = 8'hEE;
    @(negedge clk); wr_n = 1'b1;
    chk("R10 cs high", pa_out, 8'h6C);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule